// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block moves 8-bit bytes over a synchronous serial link and can work as either end of it. It is the clock master, generating the shift clock from a fixed divider and driving an active-low select line. Or it is the clock slave, following an external shift clock and an external select line, both brought into the system clock domain through two-flop synchronizers. A mode bit chooses between select-framed operation with four clock modes and a plain clocked-serial mode. In plain mode the select line plays no part and the timing is fixed to clock mode 0.

The two data pins swap roles with the configuration. In select-framed slave mode, the port drives its outgoing data on the pin that carries received data in every other configuration. It samples the pin that carries transmitted data elsewhere. A master, or any port in plain mode, sends on the transmit pin and receives on the receive pin. The select pin is an output in framed master mode and an input in framed slave mode.

Bytes to send enter through a one-deep valid/ready slot. `tx_ready` is high while the slot is empty. A byte is accepted on a clock where `tx_valid` and `tx_ready` are both high, and `tx_ready` stays low until the shifter takes that byte. A master takes the byte and starts a frame on its own. A slave takes it when its select input falls, and again after each completed byte while it stays selected. If the slot is empty at that moment, the slave sends zeros. Received bytes leave on `rx_data` with a one-cycle `rx_valid` strobe and no back-pressure: the consumer must capture the byte in that cycle. `rx_data` then holds until the next byte completes.

Top module: `spi_port`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, `bit_count` is 7, `sel_out` is 1 and `sck_out` equals the idle clock level.
- R2: A byte is accepted when `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the byte is loaded into the shifter. A master loads at the start of the frame. A framed slave loads only once its select input is low.
- R3: A framed master (`cfg_spi_en`=1, `cfg_master`=1) drives `sel_oe`=1. It pulls `sel_out` low exactly 2*DIV clocks before the first shift-clock edge and raises it exactly 2*DIV clocks after the 16th edge. It drives `sck_oe`=1, and `sck_out` rests at `cfg_cpol` while `sel_out` is high.
- R4: Data moves most significant bit first. With phase 0, a bit is sampled on the leading edge (the edge leaving the idle level) and the next bit is launched on the trailing edge. With phase 1, a bit is launched on the leading edge and sampled on the trailing edge. A master sends on `txd_out` (`txd_oe`=1) and samples `rxd_in`.
- R5: After the eighth sampled bit, `rx_data` holds the received byte and `rx_valid` is 1 for exactly one clock, once per byte.
- R6: A framed slave (`cfg_spi_en`=1, `cfg_master`=0) samples `txd_in` and sends on `rxd_out`. `txd_oe` is 0, `sck_oe` is 0, and `rxd_oe` is 1 only while the synchronized select input is low.
- R7: While a framed slave's select input is high, `bit_count` is 7, edges on `sck_in` have no effect and `rx_valid` stays 0. Raising select in mid-byte returns `bit_count` to 7.
- R8: A framed slave with phase 0 presents bit 7 of its loaded byte on `rxd_out` after select falls, before the first clock edge.
- R9: With `cfg_spi_en`=0, both roles send on `txd_out` and receive on `rxd_in`. `sel_oe` and `rxd_oe` are 0, a slave shifts regardless of `sel_in`, and the timing is clock mode 0 whatever `cfg_cpol` and `cfg_cpha` hold.
- R10: `bit_count` drops by one on each sampled bit and returns to 7 after the bit sampled at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spi_en | input | 1 | 1: select-framed mode with four clock modes; 0: plain clocked serial |
| cfg_master | input | 1 | 1: master with internal clock; 0: slave on external clock |
| cfg_cpol | input | 1 | Idle level of the shift clock (framed mode) |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge (framed mode) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit slot is empty |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: a byte completed |
| bit_count | output | 3 | Bits still to sample in the current byte, minus one |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sel_in | input | 1 | Active-low select from outside (framed slave) |
| sel_out | output | 1 | Active-low select to outside (master) |
| sel_oe | output | 1 | Drive enable for the select pin |
| txd_in | input | 1 | Transmit-data pin input (framed slave samples it) |
| txd_out | output | 1 | Transmit-data pin output |
| txd_oe | output | 1 | Drive enable for the transmit-data pin |
| rxd_in | input | 1 | Receive-data pin input |
| rxd_out | output | 1 | Receive-data pin output (framed slave sends on it) |
| rxd_oe | output | 1 | Drive enable for the receive-data pin |

## Verification
A shift register or counter that slips by one bit shows up within a single byte. The byte echoed by the peer model comes back rotated, and `rx_data` disagrees at the `rx_valid` strobe, which falls two or three system clocks after the eighth sampling edge. A master sequencer with a wrong timer shows up at the pins before any data moves: the gap between the select edge and the first clock edge is off by whole clocks. A slave whose hold logic is broken lets `bit_count` leave 7 on the first ignored clock edge, three system clocks after that edge reaches the pin. A wrong pin swap leaves the output enables, or the very first sampled bit, wrong at the start of the frame.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    MS_IDLE,
    MS_SETUP,
    MS_SHIFT,
    MS_HOLD
  } mseq_state_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } clk_edge_t;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            sample,
  input  logic            launch,
  input  logic            sin,
  output logic            dout,
  output logic [CW-1:0]   cnt,
  output logic [BITS-1:0] rx_byte,
  output logic            done
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= LAST;
      dout    <= 1'b0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hold) begin
        cnt <= LAST;
      end else if (load) begin
        sh   <= load_data;
        dout <= load_data[BITS-1];
        cnt  <= LAST;
      end else begin
        if (sample) begin
          sh <= {sh[BITS-2:0], sin};
          if (cnt == '0) begin
            cnt     <= LAST;
            rx_byte <= {sh[BITS-2:0], sin};
            done    <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (launch) dout <= sh[BITS-1];
      end
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == LAST || cnt == CW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/spi_port_mseq.sv
module spi_port_mseq
  import spi_port_pkg::*;
#(
  parameter int BITS = 8,
  parameter int DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      start,
  output logic      load,
  output logic      sel_n,
  output logic      tog,
  output clk_edge_t edge_o
);
  localparam int PERIOD = 2 * DIV;
  localparam int TW = $clog2(PERIOD);
  localparam int EW = $clog2(2 * BITS);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BITS - 1);

  mseq_state_e   state;
  logic [TW-1:0] timer;
  logic [EW-1:0] ecnt;
  logic          strobe;

  assign strobe       = (state == MS_SETUP || state == MS_SHIFT) && timer == '0;
  assign edge_o.lead  = strobe & ~tog;
  assign edge_o.trail = strobe & tog;
  assign load         = en && start && state == MS_IDLE;
  assign sel_n        = (state == MS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MS_IDLE;
      timer <= '0;
      ecnt  <= '0;
      tog   <= 1'b0;
    end else if (!en) begin
      state <= MS_IDLE;
      tog   <= 1'b0;
    end else begin
      case (state)
        MS_IDLE: begin
          if (load) begin
            state <= MS_SETUP;
            timer <= TW'(PERIOD - 1);
            ecnt  <= '0;
            tog   <= 1'b0;
          end
        end
        MS_SETUP, MS_SHIFT: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else begin
            tog <= ~tog;
            if (ecnt == LAST_EDGE) begin
              state <= MS_HOLD;
              timer <= TW'(PERIOD - 1);
            end else begin
              state <= MS_SHIFT;
              ecnt  <= ecnt + 1'b1;
              timer <= TW'(DIV - 1);
            end
          end
        end
        default: begin
          if (timer != '0) timer <= timer - 1'b1;
          else state <= MS_IDLE;
        end
      endcase
    end
  end

  // R3
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !tog);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int BITS = 8,
  parameter int DIV = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_spi_en,
  input  logic            cfg_master,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid,
  output logic [CW-1:0]   bit_count,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sck_oe,
  input  logic            sel_in,
  output logic            sel_out,
  output logic            sel_oe,
  input  logic            txd_in,
  output logic            txd_out,
  output logic            txd_oe,
  input  logic            rxd_in,
  output logic            rxd_out,
  output logic            rxd_oe
);
  logic [3:0] pins_s;
  logic       sck_s, sel_s, txd_s, rxd_s, sck_q, act_q;
  logic       cpol_e, cpha_e, slave, swap, slv_active, slv_start;
  logic       s_rise, s_fall;
  clk_edge_t  s_edge, m_edge, edge_sel;
  logic       m_load, m_sel_n, m_tog;
  logic       sample, launch, hold, load, sin, dout, done;
  logic [BITS-1:0] txbuf;
  logic            txfull;

  spi_port_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, sel_in, txd_in, rxd_in}),
    .q(pins_s)
  );
  assign {sck_s, sel_s, txd_s, rxd_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      act_q <= slave & slv_active;
    end
  end

  assign cpol_e     = cfg_spi_en & cfg_cpol;
  assign cpha_e     = cfg_spi_en & cfg_cpha;
  assign slave      = ~cfg_master;
  assign swap       = slave & cfg_spi_en;
  assign slv_active = cfg_spi_en ? ~sel_s : 1'b1;
  assign slv_start  = slave & slv_active & ~act_q;

  assign s_rise       = sck_s & ~sck_q;
  assign s_fall       = ~sck_s & sck_q;
  assign s_edge.lead  = slv_active & (cpol_e ? s_fall : s_rise);
  assign s_edge.trail = slv_active & (cpol_e ? s_rise : s_fall);

  spi_port_mseq #(.BITS(BITS), .DIV(DIV)) u_mseq (
    .clk(clk), .rst_n(rst_n),
    .en(cfg_master), .start(txfull),
    .load(m_load), .sel_n(m_sel_n), .tog(m_tog), .edge_o(m_edge)
  );

  assign edge_sel = cfg_master ? m_edge : s_edge;
  assign sample   = cpha_e ? edge_sel.trail : edge_sel.lead;
  assign launch   = cpha_e ? edge_sel.lead : edge_sel.trail;
  assign hold     = slave & ~slv_active;
  assign load     = cfg_master ? m_load : (slv_start | (slave & slv_active & done));
  assign sin      = cfg_master ? rxd_in : (swap ? txd_s : rxd_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf  <= '0;
      txfull <= 1'b0;
    end else begin
      if (load) txfull <= 1'b0;
      if (tx_valid && !txfull) begin
        txbuf  <= tx_data;
        txfull <= 1'b1;
      end
    end
  end

  spi_port_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .hold(hold), .load(load), .load_data(txfull ? txbuf : '0),
    .sample(sample), .launch(launch), .sin(sin),
    .dout(dout), .cnt(bit_count), .rx_byte(rx_data), .done(done)
  );

  assign tx_ready = ~txfull;
  assign rx_valid = done;
  assign sck_out  = cpol_e ^ m_tog;
  assign sck_oe   = cfg_master;
  assign sel_out  = m_sel_n;
  assign sel_oe   = cfg_master & cfg_spi_en;
  assign txd_out  = dout;
  assign txd_oe   = ~swap;
  assign rxd_out  = dout;
  assign rxd_oe   = swap & slv_active;

  // R7
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && cfg_spi_en && sel_s) |=> (bit_count == CW'(BITS - 1)));

  // R2
  accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxd_oe && txd_oe));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && sel_out) |-> (sck_out == cpol_e));
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int DIV = 4;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_spi_en = 1'b1, cfg_master = 1'b1, cfg_cpol = 1'b1, cfg_cpha = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, rx_valid, sck_out, sck_oe, sel_out, sel_oe;
  logic txd_out, txd_oe, rxd_out, rxd_oe;
  logic [7:0] rx_data;
  logic [2:0] bit_count;
  logic sck_in = 1'b0, sel_in = 1'b1, txd_in = 1'b0, rxd_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  logic [7:0] last_rx = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_port uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_spi_en(cfg_spi_en), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .bit_count(bit_count),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe),
    .txd_in(txd_in), .txd_out(txd_out), .txd_oe(txd_oe),
    .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe)
  );

  always @(negedge clk) if (rx_valid) begin
    vcnt++;
    last_rx = rx_data;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // bench acts as the slave peer of a master-mode port
  task automatic run_master(input bit en, input bit pol, input bit pha,
                            input logic [7:0] tb, input logic [7:0] sb);
    bit epol = en & pol;
    bit epha = en & pha;
    logic [7:0] cap = '0;
    int edges = 0, nb = 6, ki = 0, cyc = 0;
    int t_fall = -1, t_first = -1, t_last = -1, t_rise = -1, v0;
    logic psck, psel;
    @(negedge clk);
    cfg_master = 1'b1; cfg_spi_en = en; cfg_cpol = pol; cfg_cpha = pha;
    @(negedge clk);
    chk("R3 idle clock level", sck_out, epol);
    chk("R3 select drive enable", sel_oe, en);
    chk("R3 clock drive enable", sck_oe, 1);
    chk("R4 master drives txd", txd_oe, 1);
    rxd_in = epha ? 1'b0 : sb[7];
    psck = sck_out; psel = 1'b1; v0 = vcnt;
    write_tx(tb);
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      cyc++;
      if (sel_out != psel) begin
        if (!sel_out) t_fall = cyc; else t_rise = cyc;
        psel = sel_out;
      end
      if (sck_out != psck) begin
        edges++;
        psck = sck_out;
        if (t_first < 0) t_first = cyc;
        t_last = cyc;
        if (!epha) begin
          if (edges % 2 == 1) cap = {cap[6:0], txd_out};
          else if (nb >= 0) begin rxd_in = sb[nb]; nb--; end
        end else begin
          if (edges % 2 == 1) begin rxd_in = sb[7-ki]; ki++; end
          else cap = {cap[6:0], txd_out};
        end
      end
      if (t_rise >= 0) break;
    end
    chk("R4 edges per byte", edges, 16);
    chk("R4 master sent byte", cap, tb);
    chk("R5 master received byte", last_rx, sb);
    chk("R5 one strobe per byte", vcnt - v0, 1);
    if (en) begin
      chk("R3 select lead time", t_first - t_fall, 2 * DIV);
      chk("R3 select trail time", t_rise - t_last, 2 * DIV);
    end
    chk("R3 clock back at idle", sck_out, epol);
    chk("R2 slot free after frame", tx_ready, 1);
  endtask

  task automatic drive_in(input bit en, input logic v);
    if (en) txd_in = v; else rxd_in = v;
  endtask

  // bench acts as the master peer of a slave-mode port
  task automatic run_slave(input bit en, input bit pol, input bit pha,
                           input logic [7:0] tb, input logic [7:0] mb);
    bit epol = en & pol;
    bit epha = en & pha;
    logic [7:0] cap = '0;
    int v0;
    @(negedge clk);
    cfg_master = 1'b0; cfg_spi_en = 1'b1; sel_in = 1'b1;
    sck_in = epol; txd_in = 1'b0; rxd_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 count held while deselected", bit_count, 7);
    chk("R6 slave output off while deselected", rxd_oe, 0);
    write_tx(tb);
    repeat (2) @(negedge clk);
    chk("R2 slave waits for select", tx_ready, 0);
    cfg_spi_en = en; cfg_cpol = pol; cfg_cpha = pha;
    if (en) sel_in = 1'b0;
    v0 = vcnt;
    if (!epha) drive_in(en, mb[7]);
    repeat (2 * H) @(negedge clk);
    chk("R2 slave took byte", tx_ready, 1);
    if (en) begin
      chk("R6 slave drives rxd", rxd_oe, 1);
      chk("R6 slave releases txd", txd_oe, 0);
      chk("R6 slave clock not driven", sck_oe, 0);
    end else begin
      chk("R9 plain slave drives txd", txd_oe, 1);
      chk("R9 plain slave rxd off", rxd_oe, 0);
      chk("R9 select not driven", sel_oe, 0);
    end
    if (!epha) chk("R8 first bit before first edge", en ? rxd_out : txd_out, tb[7]);
    for (int i = 0; i < 8; i++) begin
      if (!epha) begin
        cap = {cap[6:0], (en ? rxd_out : txd_out)};
        sck_in = ~epol;
        repeat (H) @(negedge clk);
        chk("R10 count after sample", bit_count, (7 - (i + 1)) & 7);
        sck_in = epol;
        if (i < 7) drive_in(en, mb[6-i]);
        repeat (H) @(negedge clk);
      end else begin
        sck_in = ~epol;
        drive_in(en, mb[7-i]);
        repeat (H) @(negedge clk);
        cap = {cap[6:0], (en ? rxd_out : txd_out)};
        sck_in = epol;
        repeat (H) @(negedge clk);
        chk("R10 count after sample", bit_count, (7 - (i + 1)) & 7);
      end
    end
    chk("R5 slave received byte", last_rx, mb);
    chk("R5 one strobe per byte", vcnt - v0, 1);
    chk(en ? "R6 slave sent byte" : "R9 plain slave sent byte", cap, tb);
    sel_in = 1'b1;
    repeat (6) @(negedge clk);
    if (en) begin
      chk("R7 count reset on deselect", bit_count, 7);
      chk("R6 output off after deselect", rxd_oe, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 bit_count", bit_count, 7);
    chk("R1 sel_out", sel_out, 1);
    chk("R1 sck_out", sck_out, 1);

    // directed master corners, four modes
    run_master(1, 0, 0, 8'hA5, 8'h3C);
    run_master(1, 0, 1, 8'hFF, 8'h00);
    run_master(1, 1, 0, 8'h00, 8'hFF);
    run_master(1, 1, 1, 8'h81, 8'h7E);
    // plain mode master with polarity and phase bits set: ignored (R9)
    run_master(0, 1, 1, 8'hC3, 8'h5A);
    for (int n = 0; n < 6; n++) begin
      run_master(1, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    // directed slave corners
    run_slave(1, 0, 0, 8'h96, 8'h1E);
    run_slave(1, 1, 1, 8'h01, 8'h80);
    run_slave(0, 1, 1, 8'hB4, 8'h4B);
    for (int n = 0; n < 6; n++) begin
      run_slave(1, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    // R7: clock edges with select high are ignored
    @(negedge clk);
    cfg_master = 1'b0; cfg_spi_en = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    sel_in = 1'b1; sck_in = 1'b0;
    v0 = vcnt;
    for (int n = 0; n < 20; n++) begin
      sck_in = ~sck_in;
      txd_in = 1'($urandom);
      repeat (4) @(negedge clk);
    end
    chk("R7 count stays 7 with select high", bit_count, 7);
    chk("R7 no strobe with select high", vcnt - v0, 0);
    chk("R7 output off with select high", rxd_oe, 0);

    // R7/R10: abort mid-byte
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    sel_in = 1'b0;
    repeat (2 * H) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      sck_in = 1'b1; repeat (H) @(negedge clk);
      sck_in = 1'b0; repeat (H) @(negedge clk);
    end
    chk("R10 count after three samples", bit_count, 4);
    sel_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 abort returns count to 7", bit_count, 7);
    chk("R7 abort gives no strobe", vcnt - v0, 0);
    run_slave(1, 0, 0, 8'h5C, 8'hE7);
    run_master(1, 0, 0, 8'h24, 8'h42);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule